// File: doc/BRIEF.md
# Floating-Point Invalid-Operation and Denormal-Operand Detector

This block sits next to a single-precision arithmetic unit that performs add, subtract, multiply, divide and the three compares. For every operation it classifies both operands. It then decides whether the operation is invalid under IEEE-style rules, or whether an unimplemented-operand condition applies because a denormal reached the unit while flushing was off. From that outcome it chooses what reaches the destination register. The arithmetic result itself is computed by the neighbouring datapath and passed in. This block substitutes a quiet NaN or an unordered compare code for it, or suppresses the write and raises a trap request instead.

Two control bits from the floating-point status word steer the behaviour: an invalid-trap enable and a denormal-flush enable. The invalid condition is maskable. The unimplemented condition is not, and it outranks the invalid condition when both apply. All outputs are registered. They appear on the cycle after the input strobe, together with an output strobe.

Top module: `fpinv_top`

## Requirements
- R1: The outputs for an operation presented with `in_valid` high are registered and appear on the next clock edge with `out_valid` high. While `out_valid` is low, `flag_invalid`, `flag_unimpl`, `trap_req` and `dest_we` are all 0.
- R2: An operand is a signalling NaN when its exponent is 0xFF, its fraction is nonzero and fraction bit 22 is 0. A signalling NaN in either operand of any operation raises `flag_invalid`.
- R3: A quiet NaN (exponent 0xFF, fraction bit 22 set) in an arithmetic operation raises no flag, and `dest_data` carries `dp_result` with `dest_we` high.
- R4: Adding infinities of opposite sign is invalid. Subtracting infinities of equal sign is invalid. Adding like-signed infinities, or subtracting unlike-signed infinities, is valid.
- R5: A multiply of zero by infinity (either order) is invalid. A divide of zero by zero or of infinity by infinity is invalid. A divide of a finite nonzero value by zero is not.
- R6: Opcodes are ADD=0, SUB=1, MUL=2, DIV=3, CMP_LT=4, CMP_GT=5, CMP_EQ=6. A less-than or greater-than compare with any NaN operand is invalid. An equality compare with a quiet NaN is not. Whenever a compare with a NaN operand writes, `dest_data` is the unordered code 0x00000008.
- R7: With `ctl_inv_en` = 0, an invalid operation writes (`dest_we` = 1, `trap_req` = 0). Arithmetic writes 0x7FC00000 and compares write 0x00000008.
- R8: With `ctl_inv_en` = 1, an invalid operation raises `trap_req` and does not write.
- R9: With `ctl_flush` = 0, a denormal operand (exponent 0, fraction nonzero) raises `flag_unimpl` and `trap_req` with `dest_we` = 0. This happens whatever the value of `ctl_inv_en`.
- R10: With `ctl_flush` = 0, `dp_res_denorm` high on an arithmetic opcode raises `flag_unimpl` in the same way.
- R11: With `ctl_flush` = 1, denormal operands and `dp_res_denorm` raise nothing, and `dp_result` is written.
- R12: When both conditions apply, only `flag_unimpl` is raised and the unimplemented handling (trap, no write) is taken.
- R13: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 3 | Opcode (see R6) |
| opnd_a | input | 32 | First operand, single precision |
| opnd_b | input | 32 | Second operand, single precision |
| dp_result | input | 32 | Result from the arithmetic datapath |
| dp_res_denorm | input | 1 | Datapath intermediate result is denormal |
| ctl_inv_en | input | 1 | Invalid-operation trap enable |
| ctl_flush | input | 1 | Denormal flush-to-zero enable |
| out_valid | output | 1 | Results valid strobe |
| flag_invalid | output | 1 | Invalid-operation detected |
| flag_unimpl | output | 1 | Unimplemented-operand detected |
| trap_req | output | 1 | Trap request |
| dest_we | output | 1 | Destination write enable |
| dest_data | output | 32 | Value for the destination register |

## Verification
Every result of this block — both flags, the trap request, the write enable and the substituted data — is due exactly one clock edge after the strobe that carried its operation. There is no path that takes longer or shorter. The driver presents each operation on a falling edge and records the expected outcome in a queue. The monitor samples on each later falling edge, where `out_valid` is high, and compares the oldest queued item there. Back-to-back operations therefore line up one-to-one with no slack. An output strobe with an empty queue, or a queue left non-empty after the idle tail, counts as a failure.

// File: rtl/fpinv_pkg.sv
package fpinv_pkg;

    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;

    localparam logic [WORD_W-1:0] QNAN_DEFAULT = 32'h7FC0_0000;
    localparam logic [WORD_W-1:0] CMP_UNORDERED = 32'h0000_0008;

    typedef enum logic [2:0] {
        OP_ADD    = 3'd0,
        OP_SUB    = 3'd1,
        OP_MUL    = 3'd2,
        OP_DIV    = 3'd3,
        OP_CMP_LT = 3'd4,
        OP_CMP_GT = 3'd5,
        OP_CMP_EQ = 3'd6,
        OP_RSVD   = 3'd7
    } fp_op_e;

    typedef struct packed {
        logic sign;
        logic is_zero;
        logic is_inf;
        logic is_snan;
        logic is_qnan;
        logic is_den;
    } fp_cls_t;

    typedef struct packed {
        logic                invalid;
        logic                unimpl;
        logic                trap;
        logic                we;
        logic [WORD_W-1:0]   data;
    } fp_dec_t;

    function automatic logic op_is_arith(fp_op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_MUL) || (op == OP_DIV);
    endfunction

    function automatic logic op_is_cmp(fp_op_e op);
        return (op == OP_CMP_LT) || (op == OP_CMP_GT) || (op == OP_CMP_EQ);
    endfunction

endpackage

// File: rtl/fpinv_classify.sv
module fpinv_classify
    import fpinv_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int FW = FRAC_W
) (
    input  logic [EW+FW:0] word,
    output fp_cls_t        cls
);
    localparam int QBIT = FW - 1;

    logic [EW-1:0] expo;
    logic [FW-1:0] frac;
    logic          exp_max;
    logic          exp_min;
    logic          frac_nz;

    assign expo    = word[FW +: EW];
    assign frac    = word[FW-1:0];
    assign exp_max = &expo;
    assign exp_min = ~|expo;
    assign frac_nz = |frac;

    always_comb begin
        cls.sign    = word[EW+FW];
        cls.is_zero = exp_min & ~frac_nz;
        cls.is_den  = exp_min &  frac_nz;
        cls.is_inf  = exp_max & ~frac_nz;
        cls.is_qnan = exp_max &  frac[QBIT];
        cls.is_snan = exp_max &  frac_nz & ~frac[QBIT];
    end
endmodule

// File: rtl/fpinv_rules.sv
module fpinv_rules
    import fpinv_pkg::*;
(
    input  fp_op_e              op,
    input  fp_cls_t             ca,
    input  fp_cls_t             cb,
    input  logic [WORD_W-1:0]   dp_result,
    input  logic                res_den,
    input  logic                inv_en,
    input  logic                flush,
    output fp_dec_t             dec
);
    logic any_snan;
    logic any_nan;
    logic both_inf;
    logic op_rule;
    logic invalid_c;
    logic unimpl_c;
    logic is_cmp;

    assign any_snan = ca.is_snan | cb.is_snan;
    assign any_nan  = any_snan | ca.is_qnan | cb.is_qnan;
    assign both_inf = ca.is_inf & cb.is_inf;
    assign is_cmp   = op_is_cmp(op);

    always_comb begin
        unique case (op)
            OP_ADD:    op_rule = both_inf &  (ca.sign ^ cb.sign);
            OP_SUB:    op_rule = both_inf & ~(ca.sign ^ cb.sign);
            OP_MUL:    op_rule = (ca.is_zero & cb.is_inf) | (ca.is_inf & cb.is_zero);
            OP_DIV:    op_rule = (ca.is_zero & cb.is_zero) | both_inf;
            OP_CMP_LT,
            OP_CMP_GT: op_rule = any_nan;
            default:   op_rule = 1'b0;
        endcase
    end

    assign invalid_c = any_snan | op_rule;
    assign unimpl_c  = ~flush & (ca.is_den | cb.is_den | (op_is_arith(op) & res_den));

    always_comb begin
        dec = '0;
        if (unimpl_c) begin
            dec.unimpl = 1'b1;
            dec.trap   = 1'b1;
            dec.we     = 1'b0;
            dec.data   = dp_result;
        end else if (invalid_c) begin
            dec.invalid = 1'b1;
            dec.trap    = inv_en;
            dec.we      = ~inv_en;
            dec.data    = is_cmp ? CMP_UNORDERED : QNAN_DEFAULT;
        end else begin
            dec.we   = 1'b1;
            dec.data = (is_cmp && any_nan) ? CMP_UNORDERED : dp_result;
        end
    end
endmodule

// File: rtl/fpinv_top.sv
module fpinv_top
    import fpinv_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [2:0]          op,
    input  logic [WORD_W-1:0]   opnd_a,
    input  logic [WORD_W-1:0]   opnd_b,
    input  logic [WORD_W-1:0]   dp_result,
    input  logic                dp_res_denorm,
    input  logic                ctl_inv_en,
    input  logic                ctl_flush,
    output logic                out_valid,
    output logic                flag_invalid,
    output logic                flag_unimpl,
    output logic                trap_req,
    output logic                dest_we,
    output logic [WORD_W-1:0]   dest_data
);
    localparam int NUM_OPND = 2;

    logic [WORD_W-1:0] opnd_arr [NUM_OPND];
    fp_cls_t           cls_arr  [NUM_OPND];
    fp_dec_t           dec;

    assign opnd_arr[0] = opnd_a;
    assign opnd_arr[1] = opnd_b;

    for (genvar i = 0; i < NUM_OPND; i++) begin : g_cls
        fpinv_classify #(.EW(EXP_W), .FW(FRAC_W)) u_cls (
            .word (opnd_arr[i]),
            .cls  (cls_arr[i])
        );
    end

    fpinv_rules u_rules (
        .op        (fp_op_e'(op)),
        .ca        (cls_arr[0]),
        .cb        (cls_arr[1]),
        .dp_result (dp_result),
        .res_den   (dp_res_denorm),
        .inv_en    (ctl_inv_en),
        .flush     (ctl_flush),
        .dec       (dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            flag_invalid <= 1'b0;
            flag_unimpl  <= 1'b0;
            trap_req     <= 1'b0;
            dest_we      <= 1'b0;
            dest_data    <= '0;
        end else begin
            out_valid    <= in_valid;
            flag_invalid <= in_valid & dec.invalid;
            flag_unimpl  <= in_valid & dec.unimpl;
            trap_req     <= in_valid & dec.trap;
            dest_we      <= in_valid & dec.we;
            if (in_valid) begin
                dest_data <= dec.data;
            end
        end
    end
endmodule

// File: rtl/fpinv_chk.sv
module fpinv_chk
    import fpinv_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                ctl_inv_en,
    input logic                ctl_flush,
    input logic                out_valid,
    input logic                flag_invalid,
    input logic                flag_unimpl,
    input logic                trap_req,
    input logic                dest_we,
    input logic [WORD_W-1:0]   dest_data
);
    assert_strobe_follows_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !(flag_invalid || flag_unimpl || trap_req || dest_we));

    assert_masked_value_R7: assert property (@(posedge clk) disable iff (rst)
        (flag_invalid && dest_we) |-> (dest_data == QNAN_DEFAULT || dest_data == CMP_UNORDERED));

    assert_trap_tracks_enable_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && flag_invalid) |-> (trap_req == $past(ctl_inv_en)));

    assert_unimpl_blocks_write_R9: assert property (@(posedge clk) disable iff (rst)
        flag_unimpl |-> (trap_req && !dest_we));

    assert_flush_silences_R11: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(ctl_flush)) |-> !flag_unimpl);

    assert_single_cause_R12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flag_invalid, flag_unimpl}));
endmodule

bind fpinv_top fpinv_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .ctl_inv_en   (ctl_inv_en),
    .ctl_flush    (ctl_flush),
    .out_valid    (out_valid),
    .flag_invalid (flag_invalid),
    .flag_unimpl  (flag_unimpl),
    .trap_req     (trap_req),
    .dest_we      (dest_we),
    .dest_data    (dest_data)
);

// File: tb/fpinv_top_test.sv
module fpinv_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] dp_result = '0;
    logic        dp_res_denorm = 1'b0;
    logic        ctl_inv_en = 1'b0;
    logic        ctl_flush = 1'b0;
    logic        out_valid, flag_invalid, flag_unimpl, trap_req, dest_we;
    logic [31:0] dest_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [31:0] PINF = 32'h7F80_0000;
    localparam logic [31:0] NINF = 32'hFF80_0000;
    localparam logic [31:0] PZ   = 32'h0000_0000;
    localparam logic [31:0] NZ   = 32'h8000_0000;
    localparam logic [31:0] SNAN = 32'h7F80_0001;
    localparam logic [31:0] QNAN = 32'h7FC0_0000;
    localparam logic [31:0] DEN  = 32'h0000_0001;
    localparam logic [31:0] ONE  = 32'h3F80_0000;
    localparam logic [31:0] TWO  = 32'h4000_0000;
    localparam logic [31:0] UNORD = 32'h0000_0008;

    localparam logic [2:0] ADD = 3'd0, SUB = 3'd1, MUL = 3'd2, DIV = 3'd3;
    localparam logic [2:0] CLT = 3'd4, CGT = 3'd5, CEQ = 3'd6;

    typedef struct packed {
        logic        inv;
        logic        un;
        logic        trap;
        logic        we;
        logic [31:0] data;
    } exp_t;

    exp_t  exp_q [$];
    string tag_q [$];

    fpinv_top uut (.*);

    always #5 clk = ~clk;

    task automatic send(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] dp, input logic rden, input logic en, input logic fl,
                        input logic e_inv, input logic e_un, input logic e_trap, input logic e_we,
                        input logic [31:0] e_data, input string tag);
        exp_t e;
        @(negedge clk);
        op = o; opnd_a = a; opnd_b = b; dp_result = dp; dp_res_denorm = rden;
        ctl_inv_en = en; ctl_flush = fl; in_valid = 1'b1;
        e.inv = e_inv; e.un = e_un; e.trap = e_trap; e.we = e_we; e.data = e_data;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R1: out_valid with nothing expected (actual 1, expected 0)");
            end else begin
                exp_t  e;
                string t;
                logic  ok;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                ok = (flag_invalid == e.inv) && (flag_unimpl == e.un) &&
                     (trap_req == e.trap) && (dest_we == e.we) &&
                     (!e.we || dest_data == e.data);
                if (!ok) begin
                    errors++;
                    $display("FAIL %s: actual inv=%0b un=%0b trap=%0b we=%0b data=%h expected inv=%0b un=%0b trap=%0b we=%0b data=%h",
                             t, flag_invalid, flag_unimpl, trap_req, dest_we, dest_data,
                             e.inv, e.un, e.trap, e.we, e.data);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++; // R13 reset state
        if ({out_valid, flag_invalid, flag_unimpl, trap_req, dest_we} != 5'b0 || dest_data != 32'h0) begin
            errors++;
            $display("FAIL R13: actual %b/%h expected 00000/00000000",
                     {out_valid, flag_invalid, flag_unimpl, trap_req, dest_we}, dest_data);
        end
        rst = 1'b0;

        // o, a, b, dp, rden, en, fl, inv, un, trap, we, data, tag
        send(ADD, ONE, ONE, TWO, 0, 0, 0, 0, 0, 0, 1, TWO, "R1 normal add");
        send(ADD, QNAN, ONE, QNAN, 0, 1, 0, 0, 0, 0, 1, QNAN, "R3 qnan add");
        send(MUL, QNAN, QNAN, QNAN, 0, 0, 0, 0, 0, 0, 1, QNAN, "R3 qnan mul");
        send(ADD, SNAN, ONE, ONE, 0, 0, 0, 1, 0, 0, 1, QNAN, "R2 R7 snan masked");
        send(MUL, ONE, SNAN, ONE, 0, 1, 0, 1, 0, 1, 0, 0, "R2 R8 snan trap");
        send(ADD, PINF, NINF, ONE, 0, 0, 0, 1, 0, 0, 1, QNAN, "R4 inf+-inf");
        send(ADD, PINF, PINF, PINF, 0, 0, 0, 0, 0, 0, 1, PINF, "R4 inf+inf valid");
        send(SUB, PINF, PINF, ONE, 0, 1, 0, 1, 0, 1, 0, 0, "R4 R8 inf-inf");
        send(SUB, NINF, NINF, ONE, 0, 0, 0, 1, 0, 0, 1, QNAN, "R4 -inf--inf");
        send(SUB, PINF, NINF, PINF, 0, 0, 0, 0, 0, 0, 1, PINF, "R4 inf--inf valid");
        send(MUL, PZ, NINF, ONE, 0, 0, 0, 1, 0, 0, 1, QNAN, "R5 0*inf");
        send(MUL, NINF, NZ, ONE, 0, 1, 0, 1, 0, 1, 0, 0, "R5 inf*0 trap");
        send(DIV, PZ, NZ, ONE, 0, 0, 0, 1, 0, 0, 1, QNAN, "R5 0/0");
        send(DIV, PINF, NINF, ONE, 0, 1, 0, 1, 0, 1, 0, 0, "R5 inf/inf trap");
        send(DIV, ONE, PZ, PINF, 0, 0, 0, 0, 0, 0, 1, PINF, "R5 1/0 valid");
        send(CLT, QNAN, ONE, 32'h1, 0, 0, 0, 1, 0, 0, 1, UNORD, "R6 R7 lt nan masked");
        send(CGT, ONE, QNAN, 32'h4, 0, 1, 0, 1, 0, 1, 0, 0, "R6 gt nan trap");
        send(CEQ, QNAN, ONE, 32'h2, 0, 1, 0, 0, 0, 0, 1, UNORD, "R6 eq qnan quiet");
        send(CEQ, SNAN, ONE, 32'h2, 0, 0, 0, 1, 0, 0, 1, UNORD, "R6 eq snan");
        send(CLT, ONE, TWO, 32'h1, 0, 1, 0, 0, 0, 0, 1, 32'h1, "R6 lt ordinary");
        send(ADD, DEN, ONE, ONE, 0, 0, 0, 0, 1, 1, 0, 0, "R9 denorm masked");
        send(CGT, ONE, DEN, 32'h4, 0, 1, 0, 0, 1, 1, 0, 0, "R9 denorm enabled");
        send(MUL, ONE, ONE, ONE, 1, 0, 0, 0, 1, 1, 0, 0, "R10 denorm result");
        send(CLT, ONE, TWO, 32'h1, 1, 0, 0, 0, 0, 0, 1, 32'h1, "R10 cmp ignores res flag");
        send(ADD, DEN, ONE, ONE, 0, 0, 1, 0, 0, 0, 1, ONE, "R11 flush operand");
        send(MUL, ONE, TWO, DEN, 1, 1, 1, 0, 0, 0, 1, DEN, "R11 flush result");
        send(ADD, DEN, SNAN, ONE, 0, 0, 0, 0, 1, 1, 0, 0, "R12 unimpl over invalid");
        send(DIV, PZ, DEN, ONE, 0, 1, 0, 0, 1, 1, 0, 0, "R12 div denorm");
        idle(4);

        checks++; // R1 idle outputs quiet and every result consumed
        if (out_valid || trap_req || dest_we || exp_q.size() != 0) begin
            errors++;
            $display("FAIL R1: actual valid=%0b trap=%0b we=%0b pending=%0d expected 0 0 0 0",
                     out_valid, trap_req, dest_we, exp_q.size());
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule